// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the active-high general reset for a network physical-layer core. The reset has three sources. The first is the external hardware reset pin. The second is a software reset request, written as a self-clearing bit in management control register 0. The third is the moment the device leaves its power-down state. The pin takes effect at once. The software and power-down sources are held for a settling interval of `STRETCH_US` microseconds, which gives the clock generators time to lock. A new software request made while a hold is running starts the interval over from the beginning. The whole sequence stays far inside the half-second limit that the management standard allows for a software reset.

There are two further resets for the management register file. The first, the register reset, follows the pin and the software request. It does not respond to power-down, so register contents survive that state. The second, the keep reset, follows only the pin. It is meant for the few register bits that must survive a software reset.

The block also outputs a data-interface rate select. It holds the slow rate while the general reset is active and for `SLOW_US` microseconds afterwards. After that it selects the fast rate when auto-negotiation is enabled.

Top module: `gen_reset_seq`

## Requirements
- R1: While `hw_rst_n` is low, `gen_rst`, `mgmt_rst` and `keep_rst` are 1 without waiting for a clock edge, `sw_rst_bit` is 0 and `rate_fast` is 0.
- R2: After `hw_rst_n` rises, `gen_rst`, `mgmt_rst` and `keep_rst` fall on the second rising clock edge.
- R3: A write sampled at edge k with `cfg_wr_addr` = 0 and `cfg_wr_data` bit 15 = 1 sets `gen_rst`, `mgmt_rst` and `sw_rst_bit` to 1. They are 1 just after edge k and stay 1 until edge k+STRETCH_CYC, where they clear. `keep_rst` stays 0 throughout.
- R4: A write to any other address, or a write to address 0 with bit 15 = 0, leaves every output unchanged.
- R5: A software request that arrives while a software hold is running restarts the full STRETCH_CYC count from the edge at which it is sampled.
- R6: When `pwr_down` is sampled high at one edge and low at the next edge k, `gen_rst` is 1 from edge k to edge k+STRETCH_CYC. During this time `mgmt_rst` and `sw_rst_bit` stay 0. Entering power-down causes no reset.
- R7: When a power-down hold and a software hold overlap, `gen_rst` stays 1 until the later of the two ends. `mgmt_rst` covers only the software window.
- R8: `rate_fast` is 0 while `gen_rst` is 1 and for SLOW_CYC rising edges after `gen_rst` falls. After that, `rate_fast` equals `aneg_en`.
- R9: A software reset write made while the synchronised hardware reset is still active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| cfg_wr_en | input | 1 | Management register write strobe |
| cfg_wr_addr | input | ADDR_W | Management register address |
| cfg_wr_data | input | DATA_W | Management register write data |
| pwr_down | input | 1 | Power-down state, high while powered down |
| aneg_en | input | 1 | Auto-negotiation enable |
| gen_rst | output | 1 | General reset, active high |
| mgmt_rst | output | 1 | Management register reset (pin and software only) |
| keep_rst | output | 1 | Reset for bits that survive a software reset (pin only) |
| sw_rst_bit | output | 1 | Readback of the self-clearing software reset bit |
| rate_fast | output | 1 | 1 selects the fast data rate, 0 the slow rate |

## Verification
The timing the checks rely on is as follows:
- Software and power-down requests are registered at the edge that samples them. Their reset outputs are therefore already 1 when sampled one time unit after that edge, and they clear exactly STRETCH_CYC edges later.
- The pin release passes through two flops, so the resets clear after the second edge.
- The rate select needs SLOW_CYC further edges after the general reset falls before it turns fast.
- Pin assertion is checked with no clock edge in between.

The bench drives every input at the falling edge and compares all five outputs one time unit after each rising edge. Each row of the vector table therefore names the value due after exactly one more edge.

// File: rtl/gen_reset_pkg.sv
package gen_reset_pkg;

    // Index of each stretched reset source in the per-source arrays.
    typedef enum int unsigned {
        SRC_SW = 0,
        SRC_PD = 1
    } src_e;

    localparam int unsigned NUM_SRC = 2;

    // Data-interface rate selection.
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Converts a time in microseconds into clock cycles, never fewer than one.
    function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned us);
        int unsigned cyc;
        cyc = (clk_hz / 1_000_000) * us;
        return (cyc == 0) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/grs_sync.sv
// Reset synchroniser: asserts asynchronously and releases after STAGES edges.
module grs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign srst_n = st_q.sh[STAGES-1];

endmodule

// File: rtl/grs_stretch.sv
// Holds busy high for CYC cycles after a trigger; a new trigger restarts it.
module grs_stretch #(
    parameter int unsigned CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);

    localparam int unsigned CW = $clog2(CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.cnt = CW'(CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/grs_rate_hold.sv
// Keeps the slow rate while held and for CYC edges after the hold ends.
module grs_rate_hold
    import gen_reset_pkg::*;
#(
    parameter int unsigned CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic aneg_en,
    output logic fast
);

    localparam int unsigned CW = $clog2(CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rate_st_t;

    rate_st_t st_d, st_q;
    rate_e    sel;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.cnt = CW'(CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(CYC);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel = RATE_SLOW;
        if ((st_q.cnt == '0) && !hold && aneg_en) begin
            sel = RATE_FAST;
        end
    end

    assign fast = (sel == RATE_FAST);

endmodule

// File: rtl/gen_reset_seq.sv
module gen_reset_seq
    import gen_reset_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 25_000_000,
    parameter int unsigned STRETCH_US = 256,
    parameter int unsigned SLOW_US    = 16,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CTRL_ADDR  = 0,
    parameter int unsigned SW_BIT     = 15,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              pwr_down,
    input  logic              aneg_en,
    output logic              gen_rst,
    output logic              mgmt_rst,
    output logic              keep_rst,
    output logic              sw_rst_bit,
    output logic              rate_fast
);

    localparam int unsigned STRETCH_CYC = us_to_cycles(CLK_HZ, STRETCH_US);
    localparam int unsigned SLOW_CYC    = us_to_cycles(CLK_HZ, SLOW_US);

    typedef struct packed {
        logic pd;   // power-down level seen at the previous edge
    } top_st_t;

    top_st_t st_d, st_q;

    logic               hw_sync_n;
    logic [NUM_SRC-1:0] src_trig;
    logic [NUM_SRC-1:0] src_busy;
    logic               sw_req;
    logic               pd_exit;

    grs_sync #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk    (clk),
        .arst_n (hw_rst_n),
        .srst_n (hw_sync_n)
    );

    always_comb begin
        sw_req  = cfg_wr_en
                  && (cfg_wr_addr == ADDR_W'(CTRL_ADDR))
                  && cfg_wr_data[SW_BIT];
        pd_exit = st_q.pd && !pwr_down;

        src_trig         = '0;
        src_trig[SRC_SW] = sw_req;
        src_trig[SRC_PD] = pd_exit;

        st_d    = st_q;
        st_d.pd = pwr_down;
    end

    always_ff @(posedge clk or negedge hw_sync_n) begin
        if (!hw_sync_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        grs_stretch #(
            .CYC (STRETCH_CYC)
        ) u_stretch (
            .clk   (clk),
            .rst_n (hw_sync_n),
            .trig  (src_trig[gi]),
            .busy  (src_busy[gi])
        );
    end

    assign keep_rst   = !hw_sync_n;
    assign mgmt_rst   = keep_rst || src_busy[SRC_SW];
    assign gen_rst    = mgmt_rst || src_busy[SRC_PD];
    assign sw_rst_bit = src_busy[SRC_SW];

    grs_rate_hold #(
        .CYC (SLOW_CYC)
    ) u_rate (
        .clk     (clk),
        .rst_n   (hw_sync_n),
        .hold    (gen_rst),
        .aneg_en (aneg_en),
        .fast    (rate_fast)
    );

endmodule

// File: rtl/gen_reset_seq_chk.sv
module gen_reset_seq_chk #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned SW_BIT    = 15
) (
    input logic              clk,
    input logic              hw_rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_wr_addr,
    input logic [DATA_W-1:0] cfg_wr_data,
    input logic              pwr_down,
    input logic              aneg_en,
    input logic              gen_rst,
    input logic              mgmt_rst,
    input logic              keep_rst,
    input logic              sw_rst_bit,
    input logic              rate_fast
);

    logic sw_req;
    assign sw_req = cfg_wr_en && (cfg_wr_addr == ADDR_W'(CTRL_ADDR))
                    && cfg_wr_data[SW_BIT];

    a_r1_hw_forces_all: assert property (@(posedge clk)
        !hw_rst_n |-> (gen_rst && mgmt_rst && keep_rst && !sw_rst_bit && !rate_fast));

    a_r3_bit_implies_mgmt: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst_bit |-> (mgmt_rst && !keep_rst));

    a_r5_request_holds: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_req && !keep_rst) |=> (sw_rst_bit && mgmt_rst));

    a_r6_pd_exit_resets: assert property (@(posedge clk) disable iff (!hw_rst_n)
        ($fell(pwr_down) && !keep_rst && !$past(keep_rst)) |=> gen_rst);

    a_r6_mgmt_needs_sw: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(mgmt_rst) |-> $past(sw_req));

    a_r7_mgmt_implies_gen: assert property (@(posedge clk) disable iff (!hw_rst_n)
        mgmt_rst |-> gen_rst);

    a_r8_slow_in_reset: assert property (@(posedge clk) disable iff (!hw_rst_n)
        gen_rst |-> !rate_fast);

    a_r8_fast_needs_aneg: assert property (@(posedge clk) disable iff (!hw_rst_n)
        rate_fast |-> aneg_en);

endmodule

bind gen_reset_seq gen_reset_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .SW_BIT    (SW_BIT)
) u_chk (.*);

// File: tb/gen_reset_seq_tb.sv
module gen_reset_seq_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned N_CYC  = 6;   // stretch: 1 MHz x 6 us
    localparam int unsigned S_CYC  = 3;   // slow hold: 1 MHz x 3 us
    localparam int NROWS = 27;

    // {rep[17:14], wr[13], addr[12:8], bit15[7], pd[6], aneg[5],
    //  expected {gen, mgmt, keep, sw, fast}[4:0]}
    localparam logic [17:0] VEC [NROWS] = '{
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}, // R8 idle fast
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R8 aneg off
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}, // R8 aneg on
        {4'd1, 1'b1, 5'd1, 1'b1, 1'b0, 1'b1, 5'b00001}, // R4 wrong address
        {4'd1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}, // R4 bit 15 clear
        {4'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 5'b11010}, // R3 request
        {4'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b11010}, // R3 held
        {4'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00000}, // R3 released, slow
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}, // R3 fast again
        {4'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 5'b11010}, // R5 first request
        {4'd2, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b11010}, // R5
        {4'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 5'b11010}, // R5 restart
        {4'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b11010}, // R5 full count again
        {4'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00000}, // R5
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}, // R5
        {4'd2, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 5'b00001}, // R6 entering pd
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b10000}, // R6 pd exit
        {4'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b10000}, // R6 held, mgmt low
        {4'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00000}, // R6
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}, // R6
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 5'b00001}, // R7 pd entry
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b10000}, // R7 pd exit
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b10000}, // R7
        {4'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 5'b11010}, // R7 sw overlaps
        {4'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b11010}, // R7 later end wins
        {4'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00000}, // R7
        {4'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b00001}  // R7
    };

    logic              clk = 1'b0;
    logic              hw_rst_n;
    logic              cfg_wr_en;
    logic [ADDR_W-1:0] cfg_wr_addr;
    logic [DATA_W-1:0] cfg_wr_data;
    logic              pwr_down;
    logic              aneg_en;
    logic              gen_rst, mgmt_rst, keep_rst, sw_rst_bit, rate_fast;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gen_reset_seq #(
        .CLK_HZ     (1_000_000),
        .STRETCH_US (N_CYC),
        .SLOW_US    (S_CYC),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_dut (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .pwr_down    (pwr_down),
        .aneg_en     (aneg_en),
        .gen_rst     (gen_rst),
        .mgmt_rst    (mgmt_rst),
        .keep_rst    (keep_rst),
        .sw_rst_bit  (sw_rst_bit),
        .rate_fast   (rate_fast)
    );

    function automatic string req_of(input int row);
        if (row < 3)  return "R8";
        if (row < 5)  return "R4";
        if (row < 9)  return "R3";
        if (row < 15) return "R5";
        if (row < 20) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {gen_rst, mgmt_rst, keep_rst, sw_rst_bit, rate_fast};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: {gen,mgmt,keep,sw,fast} actual=%b expected=%b",
                     req, $time, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        hw_rst_n    = 1'b0;
        cfg_wr_en   = 1'b0;
        cfg_wr_addr = '0;
        cfg_wr_data = '0;
        pwr_down    = 1'b0;
        aneg_en     = 1'b1;
        #1;
        check("R1", 5'b11100);                       // reset state

        // R9: software reset write while the pin reset is active
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = 16'h8000;
        step();
        check("R9", 5'b11100);
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
        hw_rst_n    = 1'b1;
        step();
        check("R2", 5'b11100);                       // first edge: still held
        step();
        check("R2", 5'b00000);                       // second edge: released, R9 bit clear
        step();
        check("R8", 5'b00000);
        step();
        check("R8", 5'b00000);
        step();
        check("R8", 5'b00001);                       // fast after SLOW_CYC edges

        for (int row = 0; row < NROWS; row++) begin
            for (int r = 0; r < int'(VEC[row][17:14]); r++) begin
                @(negedge clk);
                cfg_wr_en   = VEC[row][13];
                cfg_wr_addr = VEC[row][12:8];
                cfg_wr_data = {VEC[row][7], 15'h0};
                pwr_down    = VEC[row][6];
                aneg_en     = VEC[row][5];
                step();
                check(req_of(row), VEC[row][4:0]);
            end
        end

        // R1: pin reset in the middle of a software hold, no edge needed
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = '0;
        cfg_wr_data = 16'h8000;
        step();
        check("R3", 5'b11010);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1;
        hw_rst_n = 1'b0;
        #1;
        check("R1", 5'b11100);
        @(negedge clk);
        hw_rst_n = 1'b1;
        step();
        step();
        check("R2", 5'b00000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule